// File: doc/BRIEF.md
# Serial Flash Identification Reader

This block is a self-running SPI master that fetches the two-byte identification word of a serial flash device. A one-cycle start request opens one transaction: chip select falls, an 8-bit instruction and a 24-bit address go out on MOSI, and two reply bytes are clocked in from MISO. Chip select then rises and the 16-bit result is presented with a one-cycle done strobe.

The address is all zeros except its lowest bit, which comes from a select input. The attached flash uses that bit to choose whether the manufacturer byte or the device byte is returned first. The engine packs the bytes in the order they arrive. Clock polarity is chosen per transaction for SPI mode 0 (SCK idles low) or mode 3 (SCK idles high). In both modes MISO is sampled on the rising SCK edge, and MOSI changes after the falling edge.

Top module: `spi_id_reader`

## Requirements
- R1: While reset is held and after its release, csN is 1, done is 0 and idOut is 0.
- R2: A start seen while idle drives csN low. csN stays low for the whole transaction and returns to 1 in the same cycle that done pulses. Exactly 48 rising SCK edges occur while csN is low.
- R3: The first 8 SCK cycles carry the instruction 0x90 on MOSI, most significant bit first.
- R4: SCK cycles 8 to 31 carry a 24-bit address, MSB first. Bits 23..1 are 0, and bit 0 equals addrLsb as sampled with start. A later change of addrLsb has no effect on the current transaction.
- R5: During SCK cycles 32 to 47 MOSI is held at 0, and MISO is sampled on each rising SCK edge.
- R6: The first reply byte lands in idOut[15:8] and the second in idOut[7:0], each MSB first.
- R7: Within a transaction the SCK period is CLK_DIV system clocks (8 by default), and SCK stays high for at least two cycles after each rise.
- R8: With modeHigh = 0, SCK idles low (mode 0). With modeHigh = 1, SCK idles high (mode 3). The level is taken at start.
- R9: At least CLK_DIV/2 system clocks pass between csN falling and the first SCK edge. At least as many pass between the last SCK edge and csN rising.
- R10: done is high for exactly one cycle. idOut changes only in that cycle and holds its value until the next done.
- R11: A start arriving while a transaction is open is ignored. This includes the cycle in which done is produced: no second transaction starts and the result is unchanged.
- R12: done appears a fixed 49*CLK_DIV+1 cycles after start is driven. Counted from the first clock edge after start is sampled, it is 49*CLK_DIV cycles (392 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to run an ID read |
| addrLsb | input | 1 | Value of address bit 0, selects reply order |
| modeHigh | input | 1 | 0 selects mode 0, 1 selects mode 3 |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock, system clock divided by CLK_DIV |
| mosi | output | 1 | Serial data to the flash |
| csN | output | 1 | Chip select, active low |
| idOut | output | 16 | Identification word, first reply byte in the high half |
| done | output | 1 | One-cycle strobe marking idOut valid |

## Verification
A fresh start request and the closing of the current transaction can land in the same cycle. In that cycle chip select rises, done pulses and the engine is not yet idle, so the request must be dropped. The bench provokes this by timing a start pulse onto the exact edge that produces done. It then judges that chip select stays high over the following cycles and that no further done appears. Start pulses placed at random points inside transactions are judged the same way, through an unchanged done latency and a correct identification word.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;     // load instruction and address into the transmit register
    logic shift;    // advance the transmit register by one bit
    logic sample;   // take one MISO bit into the receive register
    logic capture;  // copy the receive register to the result
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } seqState_t;

endpackage

// File: rtl/spi_id_ctrl.sv
module spi_id_ctrl
  import spi_id_pkg::*;
#(
  parameter int CLK_DIV    = 8,
  parameter int TOTAL_BITS = 48
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    modeHigh,
  output dpCtrl_t strobes,
  output logic    sck,
  output logic    csN,
  output logic    done
);

  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(TOTAL_BITS);

  seqState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             cpolQ;
  logic             sckQ;
  logic             csNQ;
  logic             doneQ;

  logic halfEnd;
  logic cycEnd;
  logic lastBit;

  generate
    if (CLK_DIV < 4 || (CLK_DIV % 2) != 0) begin : g_badDiv
      initial $error("CLK_DIV must be even and at least 4");
    end
  endgenerate

  always_comb begin
    halfEnd = (divCnt == DIV_W'(HALF - 1));
    cycEnd  = (divCnt == DIV_W'(CLK_DIV - 1));
    lastBit = (bitCnt == BIT_W'(TOTAL_BITS - 1));

    strobes.load    = (state == ST_IDLE)  && start;
    strobes.sample  = (state == ST_SHIFT) && halfEnd;
    strobes.shift   = (state == ST_SHIFT) && cycEnd && !lastBit;
    strobes.capture = (state == ST_HOLD)  && halfEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      cpolQ  <= 1'b0;
      sckQ   <= 1'b0;
      csNQ   <= 1'b1;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          sckQ <= modeHigh;
          if (start) begin
            cpolQ  <= modeHigh;
            csNQ   <= 1'b0;
            divCnt <= '0;
            bitCnt <= '0;
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (halfEnd) begin
            divCnt <= '0;
            sckQ   <= 1'b0;
            state  <= ST_SHIFT;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_SHIFT: begin
          if (cycEnd) begin
            divCnt <= '0;
            if (lastBit) begin
              sckQ  <= cpolQ;
              state <= ST_HOLD;
            end else begin
              sckQ   <= 1'b0;
              bitCnt <= bitCnt + BIT_W'(1);
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
            if (halfEnd) sckQ <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (halfEnd) begin
            divCnt <= '0;
            csNQ   <= 1'b1;
            doneQ  <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sck  = sckQ;
  assign csN  = csNQ;
  assign done = doneQ;

endmodule

// File: rtl/spi_id_dp.sv
module spi_id_dp
  import spi_id_pkg::*;
#(
  parameter int                CMD_BITS  = 8,
  parameter int                ADDR_BITS = 24,
  parameter int                ID_BITS   = 16,
  parameter logic [CMD_BITS-1:0] CMD_CODE = 8'h90
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            strobes,
  input  logic               addrLsb,
  input  logic               miso,
  output logic               mosi,
  output logic [ID_BITS-1:0] idOut
);

  localparam int TX_BITS = CMD_BITS + ADDR_BITS;

  logic [TX_BITS-1:0] txShift;
  logic [ID_BITS-1:0] rxShift;
  logic [ID_BITS-1:0] idQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      idQ     <= '0;
    end else begin
      if (strobes.load)
        txShift <= {CMD_CODE, (ADDR_BITS - 1)'(0), addrLsb};
      else if (strobes.shift)
        txShift <= {txShift[TX_BITS-2:0], 1'b0};

      if (strobes.sample)
        rxShift <= {rxShift[ID_BITS-2:0], miso};

      if (strobes.capture)
        idQ <= rxShift;
    end
  end

  assign mosi  = txShift[TX_BITS-1];
  assign idOut = idQ;

endmodule

// File: rtl/spi_id_reader.sv
module spi_id_reader
  import spi_id_pkg::*;
#(
  parameter int                  CLK_DIV   = 8,
  parameter int                  CMD_BITS  = 8,
  parameter int                  ADDR_BITS = 24,
  parameter int                  ID_BITS   = 16,
  parameter logic [CMD_BITS-1:0] CMD_CODE  = 8'h90
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               addrLsb,
  input  logic               modeHigh,
  input  logic               miso,
  output logic               sck,
  output logic               mosi,
  output logic               csN,
  output logic [ID_BITS-1:0] idOut,
  output logic               done
);

  localparam int TOTAL_BITS = CMD_BITS + ADDR_BITS + ID_BITS;

  dpCtrl_t strobes;

  spi_id_ctrl #(
    .CLK_DIV    (CLK_DIV),
    .TOTAL_BITS (TOTAL_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .modeHigh (modeHigh),
    .strobes  (strobes),
    .sck      (sck),
    .csN      (csN),
    .done     (done)
  );

  spi_id_dp #(
    .CMD_BITS  (CMD_BITS),
    .ADDR_BITS (ADDR_BITS),
    .ID_BITS   (ID_BITS),
    .CMD_CODE  (CMD_CODE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .addrLsb (addrLsb),
    .miso    (miso),
    .mosi    (mosi),
    .idOut   (idOut)
  );

endmodule

// File: rtl/spi_id_reader_chk.sv
module spi_id_reader_chk #(
  parameter int ID_BITS = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               sck,
  input logic               csN,
  input logic [ID_BITS-1:0] idOut,
  input logic               done
);

  // R2
  cs_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(start));

  // R2
  done_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $rose(csN));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  id_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(idOut));

  // R9
  cs_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |=> $stable(sck));

  // R7
  sck_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sck) && !csN) |=> sck);

endmodule

bind spi_id_reader spi_id_reader_chk #(.ID_BITS(ID_BITS)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .sck   (sck),
  .csN   (csN),
  .idOut (idOut),
  .done  (done)
);

// File: tb/spi_id_reader_tb.sv
`timescale 1ns/1ps
module spi_id_reader_tb;

  localparam int CLK_DIV = 8;
  localparam int HALF    = CLK_DIV / 2;
  localparam int NBITS   = 48;
  localparam int EXP_LAT = NBITS * CLK_DIV + CLK_DIV + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        addrLsb = 1'b0;
  logic        modeHigh = 1'b0;
  logic        miso = 1'b0;
  logic        sck;
  logic        mosi;
  logic        csN;
  logic [15:0] idOut;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_id_reader #(.CLK_DIV(CLK_DIV)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .addrLsb  (addrLsb),
    .modeHigh (modeHigh),
    .miso     (miso),
    .sck      (sck),
    .mosi     (mosi),
    .csN      (csN),
    .idOut    (idOut),
    .done     (done)
  );

  // Flash model
  logic [7:0]  manId = 8'h00;
  logic [7:0]  devId = 8'h00;
  logic [31:0] cmdAddr = '0;
  int          riseCnt = 0;
  bit          replyMosiBad = 0;

  function automatic logic [15:0] replyWord(input bit lsb, input logic [7:0] m, input logic [7:0] d);
    return lsb ? {d, m} : {m, d};
  endfunction

  always @(negedge csN) begin
    riseCnt = 0;
    cmdAddr = '0;
    replyMosiBad = 0;
  end

  always @(posedge sck) begin
    if (!csN) begin
      if (riseCnt < 32) cmdAddr = {cmdAddr[30:0], mosi};
      else if (mosi) replyMosiBad = 1;
      riseCnt++;
    end
  end

  always @(negedge sck) begin
    if (!csN && riseCnt >= 32 && riseCnt < 48) begin
      logic [15:0] w;
      w = replyWord(cmdAddr[0], manId, devId);
      miso = w[47 - riseCnt];
    end
  end

  // Pin timing monitor
  bit prevCs = 1, prevSck = 0, sawEdge = 0, firstRise = 1, periodBad = 0;
  int setupCnt = 0, setupMeas = 0, gap = 0, holdMeas = 0, sinceRise = 0;

  always @(negedge clk) begin
    if (!csN && prevCs) begin
      setupCnt = 1; sawEdge = 0; firstRise = 1; periodBad = 0; gap = 0; sinceRise = 0;
    end else if (!csN) begin
      sinceRise++;
      if (sck != prevSck) begin
        if (!sawEdge) begin sawEdge = 1; setupMeas = setupCnt; end
        gap = 0;
      end else begin
        gap++;
        if (!sawEdge) setupCnt++;
      end
      if (sck && !prevSck) begin
        if (!firstRise && sinceRise != CLK_DIV) periodBad = 1;
        firstRise = 0;
        sinceRise = 0;
      end
    end else if (csN && !prevCs) begin
      holdMeas = gap + 1;
    end
    prevCs = csN;
    prevSck = sck;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic runTxn(input logic [7:0] m, input logic [7:0] d, input bit lsb,
                        input bit mode, input int injectAt);
    int lat;
    logic [15:0] expId;
    expId = replyWord(lsb, m, d);
    @(negedge clk);
    manId = m; devId = d; addrLsb = lsb; modeHigh = mode;
    repeat (2) @(negedge clk);
    check(sck == mode && csN, "R8 idle sck level", {30'b0, csN, sck}, {30'b0, 1'b1, mode});
    start = 1'b1;
    lat = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      start = (injectAt != 0 && lat == injectAt);
      if (lat == 2) addrLsb = ~lsb;   // R4: late change must not matter
      if (done || lat > EXP_LAT + 50) break;
    end
    start = 1'b0;
    check(done, "R10 done seen", {31'b0, done}, 1);
    check(lat == EXP_LAT, "R12 done latency", lat, EXP_LAT);
    check(idOut == expId, "R6 id word", idOut, expId);
    check(csN == 1'b1, "R2 csN high at done", csN, 1);
    @(negedge clk);
    check(!done && idOut == expId, "R10 single pulse and hold", {done, idOut}, {1'b0, expId});
    check(sck == mode, "R8 sck back to idle", sck, mode);
    check(riseCnt == NBITS, "R2 rising edge count", riseCnt, NBITS);
    check(cmdAddr[31:24] == 8'h90, "R3 instruction byte", cmdAddr[31:24], 8'h90);
    check(cmdAddr[23:0] == {23'b0, lsb}, "R4 address", cmdAddr[23:0], {23'b0, lsb});
    check(!replyMosiBad, "R5 mosi low in reply", replyMosiBad, 0);
    check(!periodBad, "R7 sck period", periodBad, 0);
    check(setupMeas >= HALF, "R9 setup", setupMeas, HALF);
    check(holdMeas >= HALF, "R9 hold", holdMeas, HALF);
    if (injectAt == EXP_LAT - 1) begin
      bit stayed;
      stayed = 1;
      for (int i = 0; i < 2 * CLK_DIV; i++) begin
        @(negedge clk);
        if (!csN || done) stayed = 0;
      end
      check(stayed && idOut == expId, "R11 start in done cycle ignored", {stayed, idOut}, {1'b1, expId});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1D));
    repeat (3) @(negedge clk);
    check(csN && !done && idOut == 16'h0, "R1 reset state", {csN, done, idOut}, {2'b10, 16'h0});
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(csN && !done && idOut == 16'h0, "R1 after reset", {csN, done, idOut}, {2'b10, 16'h0});

    runTxn(8'hEF, 8'h17, 1'b0, 1'b0, 0);
    runTxn(8'hEF, 8'h17, 1'b1, 1'b1, 0);
    runTxn(8'hFF, 8'h00, 1'b0, 1'b1, 0);
    runTxn(8'h00, 8'hFF, 1'b1, 1'b0, 0);
    runTxn(8'hA5, 8'h5A, 1'b0, 1'b0, EXP_LAT - 1);   // R11 start on done edge
    runTxn(8'h3C, 8'hC3, 1'b1, 1'b1, EXP_LAT - 1);
    runTxn(8'h81, 8'h7E, 1'b0, 1'b1, 3);             // R11 start right after opening

    for (int n = 0; n < 20; n++) begin
      logic [7:0] m, d;
      int inj;
      m = 8'($urandom);
      d = 8'($urandom);
      inj = ($urandom % 3 == 0) ? int'(2 + $urandom % (EXP_LAT - 3)) : 0;
      runTxn(m, d, 1'($urandom), 1'($urandom), inj);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule